// File: doc/BRIEF.md
# Parameterized Floating-Point Adder/Subtractor

This block adds or subtracts two binary floating-point numbers whose exponent and significand widths are set by parameters. A word is laid out as sign, biased exponent and stored fraction. The significand width parameter counts the sign bit, so an 8/24 setting gives a 32-bit word with 23 stored fraction bits and an implied leading one. Gradual underflow is not supported. An operand whose exponent field is zero is read as zero, and a result too small for the smallest normal value becomes zero.

The datapath has four registered stages. The first orders the operands by magnitude and shifts the smaller one right. The second adds or subtracts the significands. The third normalizes the result so its leading bit is one. The fourth rounds to nearest with ties to even and packs the word. A valid bit travels with the data, so a new operation can enter on every cycle. An overflow flag marks results that saturate to infinity.

Top module: `fpadd_top`

## Requirements
- R1: A word is {sign, exponent[EXP_W-1:0], fraction[MAN_W-2:0]} with the sign in the top bit. A nonzero finite value is (-1)^sign × 1.fraction × 2^(exponent − bias).
- R2: out_valid is in_valid delayed by exactly 4 clock edges, and back-to-back operations come out in order. Reset clears out_valid, out_sum and out_ovf.
- R3: With in_sub = 0 the output is in_a + in_b. With in_sub = 1 it is in_a − in_b. Exact results come out exact.
- R4: Bits of the smaller operand that are shifted out during alignment still count towards rounding, through guard, round and sticky positions.
- R5: Rounding is to nearest, and an exact half-ulp tie goes to the value with an even last fraction bit, for either sign.
- R6: An operand whose exponent field is zero is treated as zero, whatever its fraction bits hold.
- R7: A nonzero result whose magnitude is below the smallest normal value is returned as all-zero bits.
- R8: Every zero result is +0 (all bits zero). This includes exact cancellation and the sum of two negative zeros.
- R9: A finite result whose rounded exponent reaches the all-ones code is returned as infinity with the result's sign: all-ones exponent, zero fraction. out_ovf is 1 exactly for these results and 0 for every other valid result.
- R10: An operand with an all-ones exponent is infinity. The output is then infinity with that operand's effective sign (the sign of in_a if in_a is infinite, otherwise the sign of in_b after the subtract select), and out_ovf stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on in_a, in_b and in_sub are to be processed |
| in_a | input | EXP_W+MAN_W | First operand |
| in_b | input | EXP_W+MAN_W | Second operand |
| in_sub | input | 1 | 1 selects in_a − in_b, 0 selects in_a + in_b |
| out_valid | output | 1 | out_sum and out_ovf hold a result |
| out_sum | output | EXP_W+MAN_W | Rounded result |
| out_ovf | output | 1 | Result overflowed and was saturated to infinity |

## Verification
The assertions assume that operands carry no unknown bits while in_valid is high. They also assume that an all-ones exponent field stands for infinity whatever its fraction holds, so NaN encodings are not given any separate meaning. The stimulus therefore uses only zeros, subnormal patterns, normal values and clean infinities. The operand pairs are chosen so that the true sum falls on a tie, just above a tie, far below the last place, beyond the largest finite value, or below the smallest normal value. These are the cases where the alignment, normalization and rounding invariants are under the most strain.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    // Guard, round and sticky bits kept below the significand.
    localparam int unsigned GRS_W = 3;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2
    } fp_class_e;

    // Control that travels alongside the datapath in every stage.
    typedef struct packed {
        logic valid;
        logic sign;
        logic is_inf;
    } lane_ctl_t;

endpackage

// File: rtl/fpa_align.sv
module fpa_align
    import fpadd_pkg::*;
#(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 24
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [EXP_W+MAN_W-1:0]     op_a,
    input  logic [EXP_W+MAN_W-1:0]     op_b,
    input  logic                       op_sub,
    output lane_ctl_t                  ctl_o,
    output logic [EXP_W-1:0]           exp_o,
    output logic [MAN_W+GRS_W-1:0]     big_o,
    output logic [MAN_W+GRS_W-1:0]     small_o,
    output logic                       eff_sub_o
);
    localparam int unsigned FRAC_W = MAN_W - 1;
    localparam int unsigned WORD_W = EXP_W + MAN_W;
    localparam int unsigned EXT_W  = MAN_W + GRS_W;

    function automatic fp_class_e classify(input logic [EXP_W-1:0] e);
        if (e == '0) return CLS_ZERO;
        if (&e)      return CLS_INF;
        return CLS_NORM;
    endfunction

    logic              sgn_a, sgn_b;
    logic [EXP_W-1:0]  exp_a, exp_b;
    logic [FRAC_W-1:0] frc_a, frc_b;
    fp_class_e         cls_a, cls_b;
    logic [WORD_W-2:0] mag_a, mag_b;
    logic [EXT_W-1:0]  ext_a, ext_b;
    logic              a_big;
    logic [EXP_W-1:0]  exp_big, exp_small, e_diff;
    logic [EXT_W-1:0]  ext_big, ext_small, shifted;
    logic [31:0]       sh32;
    logic              sticky;
    lane_ctl_t         ctl_n;

    always_comb begin
        sgn_a = op_a[WORD_W-1];
        sgn_b = op_b[WORD_W-1] ^ op_sub;
        exp_a = op_a[WORD_W-2 -: EXP_W];
        exp_b = op_b[WORD_W-2 -: EXP_W];
        frc_a = op_a[FRAC_W-1:0];
        frc_b = op_b[FRAC_W-1:0];
        cls_a = classify(exp_a);
        cls_b = classify(exp_b);
        mag_a = (cls_a == CLS_ZERO) ? '0 : {exp_a, frc_a};
        mag_b = (cls_b == CLS_ZERO) ? '0 : {exp_b, frc_b};
        ext_a = (cls_a == CLS_ZERO) ? '0 : {1'b1, frc_a, {GRS_W{1'b0}}};
        ext_b = (cls_b == CLS_ZERO) ? '0 : {1'b1, frc_b, {GRS_W{1'b0}}};
        a_big     = (mag_a >= mag_b);
        exp_big   = a_big ? exp_a : exp_b;
        exp_small = a_big ? exp_b : exp_a;
        ext_big   = a_big ? ext_a : ext_b;
        ext_small = a_big ? ext_b : ext_a;
        e_diff    = exp_big - exp_small;
    end

    // Right shift of the smaller significand, folding lost bits into sticky.
    always_comb begin
        sh32   = 32'(e_diff);
        sticky = 1'b0;
        if (sh32 >= 32'(EXT_W)) begin
            shifted = '0;
            sticky  = |ext_small;
        end else begin
            shifted = ext_small >> e_diff;
            for (int i = 0; i < int'(EXT_W); i++) begin
                if (32'(i) < sh32) sticky = sticky | ext_small[i];
            end
        end
    end

    always_comb begin
        ctl_n.valid  = in_valid;
        ctl_n.is_inf = (cls_a == CLS_INF) || (cls_b == CLS_INF);
        if (cls_a == CLS_INF)      ctl_n.sign = sgn_a;
        else if (cls_b == CLS_INF) ctl_n.sign = sgn_b;
        else                       ctl_n.sign = a_big ? sgn_a : sgn_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_o     <= '0;
            exp_o     <= '0;
            big_o     <= '0;
            small_o   <= '0;
            eff_sub_o <= 1'b0;
        end else begin
            ctl_o     <= ctl_n;
            exp_o     <= exp_big;
            big_o     <= ext_big;
            small_o   <= {shifted[EXT_W-1:1], shifted[0] | sticky};
            eff_sub_o <= sgn_a ^ sgn_b;
        end
    end

    // R4
    small_le_big_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_o.valid |-> (small_o <= big_o));

endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub
    import fpadd_pkg::*;
#(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 24
) (
    input  logic                       clk,
    input  logic                       rst,
    input  lane_ctl_t                  ctl_i,
    input  logic [EXP_W-1:0]           exp_i,
    input  logic [MAN_W+GRS_W-1:0]     big_i,
    input  logic [MAN_W+GRS_W-1:0]     small_i,
    input  logic                       eff_sub_i,
    output lane_ctl_t                  ctl_o,
    output logic [EXP_W-1:0]           exp_o,
    output logic [MAN_W+GRS_W:0]       sum_o
);
    localparam int unsigned EXT_W = MAN_W + GRS_W;

    logic [EXT_W:0] sum_n;
    logic           was_sub;

    always_comb begin
        if (eff_sub_i) sum_n = {1'b0, big_i} - {1'b0, small_i};
        else           sum_n = {1'b0, big_i} + {1'b0, small_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_o   <= '0;
            exp_o   <= '0;
            sum_o   <= '0;
            was_sub <= 1'b0;
        end else begin
            ctl_o   <= ctl_i;
            exp_o   <= exp_i;
            sum_o   <= sum_n;
            was_sub <= eff_sub_i;
        end
    end

    // R3
    no_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.valid && was_sub) |-> !sum_o[EXT_W]);

endmodule

// File: rtl/fpa_normalize.sv
module fpa_normalize
    import fpadd_pkg::*;
#(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 24
) (
    input  logic                              clk,
    input  logic                              rst,
    input  lane_ctl_t                         ctl_i,
    input  logic [EXP_W-1:0]                  exp_i,
    input  logic [MAN_W+GRS_W:0]              sum_i,
    output lane_ctl_t                         ctl_o,
    output logic signed [EXP_W+1:0]           exp_o,
    output logic [MAN_W+GRS_W-1:0]            norm_o,
    output logic                              zero_o
);
    localparam int unsigned EXT_W  = MAN_W + GRS_W;
    localparam int unsigned EXPS_W = EXP_W + 2;
    localparam int unsigned LZ_W   = $clog2(EXT_W + 1);

    logic [LZ_W-1:0]          lz;
    logic                     found;
    logic [EXT_W-1:0]         norm_n;
    logic signed [EXPS_W-1:0] exp_wide, exp_n;
    logic                     zero_n;

    // Leading-zero count below the carry position.
    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = int'(EXT_W) - 1; i >= 0; i--) begin
            if (!found) begin
                if (sum_i[i]) found = 1'b1;
                else          lz = lz + LZ_W'(1);
            end
        end
    end

    always_comb begin
        exp_wide = $signed({2'b00, exp_i});
        if (sum_i[EXT_W]) begin
            norm_n = {sum_i[EXT_W:2], sum_i[1] | sum_i[0]};
            exp_n  = exp_wide + $signed(EXPS_W'(1));
        end else begin
            norm_n = sum_i[EXT_W-1:0] << lz;
            exp_n  = exp_wide - $signed({{(EXPS_W-LZ_W){1'b0}}, lz});
        end
        zero_n = (sum_i == '0) || exp_n[EXPS_W-1] || (exp_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_o  <= '0;
            exp_o  <= '0;
            norm_o <= '0;
            zero_o <= 1'b0;
        end else begin
            ctl_o  <= ctl_i;
            exp_o  <= exp_n;
            norm_o <= norm_n;
            zero_o <= zero_n;
        end
    end

    // R1
    lead_one_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.valid && !ctl_o.is_inf && !zero_o) |-> (norm_o[EXT_W-1] && (exp_o > 0)));

endmodule

// File: rtl/fpa_round.sv
module fpa_round
    import fpadd_pkg::*;
#(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 24
) (
    input  logic                        clk,
    input  logic                        rst,
    input  lane_ctl_t                   ctl_i,
    input  logic signed [EXP_W+1:0]     exp_i,
    input  logic [MAN_W+GRS_W-1:0]      norm_i,
    input  logic                        zero_i,
    output logic                        valid_o,
    output logic [EXP_W+MAN_W-1:0]      sum_o,
    output logic                        ovf_o
);
    localparam int unsigned FRAC_W = MAN_W - 1;
    localparam int unsigned WORD_W = EXP_W + MAN_W;
    localparam int unsigned EXPS_W = EXP_W + 2;
    localparam logic signed [EXPS_W-1:0] EXP_TOP = EXPS_W'((1 << EXP_W) - 1);

    logic [MAN_W-1:0]         sig;
    logic [MAN_W:0]           sig_r;
    logic                     lsb, grd, rest, up;
    logic signed [EXPS_W-1:0] exp_r;
    logic [FRAC_W-1:0]        frac_r;
    logic [WORD_W-1:0]        word_n;
    logic                     ovf_n;

    always_comb begin
        sig    = norm_i[MAN_W+GRS_W-1:GRS_W];
        lsb    = norm_i[GRS_W];
        grd    = norm_i[GRS_W-1];
        rest   = |norm_i[GRS_W-2:0];
        up     = grd && (rest || lsb);
        sig_r  = {1'b0, sig} + {{MAN_W{1'b0}}, up};
        exp_r  = exp_i + $signed({{(EXPS_W-1){1'b0}}, sig_r[MAN_W]});
        frac_r = sig_r[MAN_W] ? '0 : sig_r[FRAC_W-1:0];
        ovf_n  = 1'b0;
        if (ctl_i.is_inf) begin
            word_n = {ctl_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (zero_i) begin
            word_n = '0;
        end else if (exp_r >= EXP_TOP) begin
            word_n = {ctl_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf_n  = 1'b1;
        end else begin
            word_n = {ctl_i.sign, exp_r[EXP_W-1:0], frac_r};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            sum_o   <= '0;
            ovf_o   <= 1'b0;
        end else begin
            valid_o <= ctl_i.valid;
            sum_o   <= word_n;
            ovf_o   <= ovf_n && ctl_i.valid;
        end
    end

    // R9
    ovf_inf_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (valid_o && (&sum_o[WORD_W-2 -: EXP_W]) && (sum_o[FRAC_W-1:0] == '0)));

    // R8
    flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && (sum_o[WORD_W-2 -: EXP_W] == '0)) |-> (sum_o == '0));

endmodule

// File: rtl/fpadd_top.sv
module fpadd_top
    import fpadd_pkg::*;
#(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [EXP_W+MAN_W-1:0]  in_a,
    input  logic [EXP_W+MAN_W-1:0]  in_b,
    input  logic                    in_sub,
    output logic                    out_valid,
    output logic [EXP_W+MAN_W-1:0]  out_sum,
    output logic                    out_ovf
);
    localparam int unsigned EXT_W = MAN_W + GRS_W;

    lane_ctl_t                ctl_1, ctl_2, ctl_3;
    logic [EXP_W-1:0]         exp_1, exp_2;
    logic [EXT_W-1:0]         big_1, small_1;
    logic                     eff_sub_1;
    logic [EXT_W:0]           sum_2;
    logic signed [EXP_W+1:0]  exp_3;
    logic [EXT_W-1:0]         norm_3;
    logic                     zero_3;

    fpa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(in_a), .op_b(in_b), .op_sub(in_sub),
        .ctl_o(ctl_1), .exp_o(exp_1), .big_o(big_1), .small_o(small_1),
        .eff_sub_o(eff_sub_1)
    );

    fpa_addsub #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_addsub (
        .clk(clk), .rst(rst), .ctl_i(ctl_1), .exp_i(exp_1),
        .big_i(big_1), .small_i(small_1), .eff_sub_i(eff_sub_1),
        .ctl_o(ctl_2), .exp_o(exp_2), .sum_o(sum_2)
    );

    fpa_normalize #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .clk(clk), .rst(rst), .ctl_i(ctl_2), .exp_i(exp_2), .sum_i(sum_2),
        .ctl_o(ctl_3), .exp_o(exp_3), .norm_o(norm_3), .zero_o(zero_3)
    );

    fpa_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
        .clk(clk), .rst(rst), .ctl_i(ctl_3), .exp_i(exp_3),
        .norm_i(norm_3), .zero_i(zero_3),
        .valid_o(out_valid), .sum_o(out_sum), .ovf_o(out_ovf)
    );

    // Edges since reset, saturating, so the latency check never looks before reset.
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                    since_rst <= '0;
        else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

endmodule

// File: tb/sim_fpadd_top.sv
`timescale 1ns/1ps
module sim_fpadd_top;

    localparam int NV = 25;

    // {a, b, sub, expected sum, expected overflow}
    localparam logic [97:0] VECS [NV] = '{
        {32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0}, // 0  R3 1+1
        {32'h40400000, 32'h3F800000, 1'b0, 32'h40800000, 1'b0}, // 1  R3 3+1
        {32'h40000000, 32'h40400000, 1'b1, 32'hBF800000, 1'b0}, // 2  R3 2-3
        {32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, 1'b0}, // 3  R3 1.5+1.5
        {32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0}, // 4  R5 tie, even stays
        {32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0}, // 5  R5 tie, odd rounds up
        {32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 1'b0}, // 6  R4 above half
        {32'h3F800000, 32'h33800000, 1'b1, 32'h3F7FFFFF, 1'b0}, // 7  R4 borrow, exact
        {32'h3F800000, 32'h33000000, 1'b1, 32'h3F800000, 1'b0}, // 8  R5 tie after renorm
        {32'h3F800000, 32'h00800000, 1'b0, 32'h3F800000, 1'b0}, // 9  R4 sticky only
        {32'h3F800000, 32'h00800000, 1'b1, 32'h3F800000, 1'b0}, // 10 R4 sticky on subtract
        {32'hBF800000, 32'hB3800000, 1'b0, 32'hBF800000, 1'b0}, // 11 R5 negative tie
        {32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1}, // 12 R9 overflow
        {32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 1'b1}, // 13 R9 negative overflow
        {32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 1'b0}, // 14 R8 cancel
        {32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 1'b0}, // 15 R8 cancel
        {32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0}, // 16 R7 flush
        {32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0}, // 17 R6 subnormal operand
        {32'h00400000, 32'h00400000, 1'b0, 32'h00000000, 1'b0}, // 18 R6 two subnormals
        {32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 1'b0}, // 19 R10 inf operand
        {32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0}, // 20 R10 minus inf
        {32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b0}, // 21 R8 -0 + -0
        {32'h00800000, 32'h00800000, 1'b0, 32'h01000000, 1'b0}, // 22 R1 exponent field
        {32'h7F000000, 32'h7F000000, 1'b0, 32'h7F800000, 1'b1}, // 23 R9 exponent carry
        {32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1}  // 24 R9 rounding carry
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2, 3:           return "R3";
            4, 5, 8, 11:          return "R5";
            6, 7, 9, 10:          return "R4";
            12, 13, 23, 24:       return "R9";
            14, 15, 21:           return "R8";
            16:                   return "R7";
            17, 18:               return "R6";
            19, 20:               return "R10";
            default:              return "R1";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        in_sub = 1'b0;
    logic        out_valid;
    logic [31:0] out_sum;
    logic        out_ovf;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fpadd_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_sub(in_sub),
        .out_valid(out_valid), .out_sum(out_sum), .out_ovf(out_ovf)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input int i);
        in_a   = VECS[i][97:66];
        in_b   = VECS[i][65:34];
        in_sub = VECS[i][33];
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R2 reset state
        check("R2", "valid in reset", 32'(out_valid), 32'd0);
        check("R2", "sum in reset",   out_sum,        32'd0);
        check("R2", "ovf in reset",   32'(out_ovf),   32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Table walk, one operation at a time
        for (int i = 0; i < NV; i++) begin
            apply(i);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            @(negedge clk);
            check("R2", "valid early", 32'(out_valid), 32'd0);
            @(negedge clk);
            check("R2", "valid on time", 32'(out_valid), 32'd1);
            check(vec_tag(i), $sformatf("sum vec %0d", i), out_sum, VECS[i][32:1]);
            check("R9", $sformatf("ovf vec %0d", i), 32'(out_ovf), 32'(VECS[i][0]));
            @(negedge clk);
        end

        // R2 back-to-back stream keeps order
        for (int c = 0; c < 8; c++) begin
            if (c >= 4 && c < 7) begin
                check("R2", $sformatf("stream valid %0d", c - 4), 32'(out_valid), 32'd1);
                check("R2", $sformatf("stream sum %0d", c - 4), out_sum, VECS[c + 1][32:1]);
            end
            if (c == 7) check("R2", "stream drained", 32'(out_valid), 32'd0);
            if (c < 3) begin
                apply(c + 5);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end

        // R2 reset mid-flight clears the pipe
        apply(0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 5; c++) begin
            check("R2", "flushed by reset", 32'(out_valid), 32'd0);
            @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule